// File: doc/BRIEF.md
# Key-Protected Stop-Mode Clock Control

This block is a one-byte control register with a two-step write guard. It decides three things: whether a stop request from the core is honoured, whether the on-chip crystal driver runs, and whether leaving stop mode waits for an oscillator stabilisation count. Software first writes the unlock key `0x55` to the register address. This write only arms the guard. The next bus write to that address is the one that updates the two control bits. An accepted interrupt in between cancels the sequence. The stored bits can be read back, so software can confirm that its write was accepted.

The stop sequencer has three states. A stop request moves it from running to stopped. A wake interrupt either resumes the core at once or starts a stabilisation count of `WAKE_CYC` cycles. Stop mode stays active until that count expires, and a one-cycle done pulse marks its end. Whether the count is used depends on the crystal-driver bit, on a system-clock-select input and on a watchdog-disable input. The disable input loses to a running crystal driver.

Top module: `stopclk_ctrl`

## Requirements
- R1: A bus write of `0x55` to the register address while the guard is not armed arms the guard and changes no stored bit.
- R2: The register resets to 0. A write to the register address while armed copies `bus_wdata[1:0]` into the stored bits, where bit 0 is the stop-block bit and bit 1 is the crystal-off bit. A write while not armed stores nothing. `bus_rdata` returns `{6'b0, bits}` when `bus_addr` selects the register, and 0 for any other address.
- R3: An `irq_ack` in the cycle of the key write, or in any cycle while armed, disarms the guard and discards any register write in that same cycle.
- R4: A write to any other address, or an unarmed write of a value other than the key, leaves the guard disarmed. Arming covers exactly one following write.
- R5: While running, a `stop_req` with bit 0 = 0 raises `stop_active` in the next cycle. With bit 0 = 1 the request is ignored.
- R6: `xout_high` equals bit 1. Outside stop, `osc_en` is the inverse of bit 1.
- R7: On a `wake_irq` in stop with bit 1 = 0, the stabilisation count is always used, whatever `sysclk_sel` and `wdt_off` are.
- R8: On a `wake_irq` in stop with bit 1 = 1, the count is used only if `sysclk_sel` = 1 and `wdt_off` = 0. Otherwise `stop_active` falls in the next cycle, with no start pulse and no done pulse.
- R9: When the count is used, `wdt_start` pulses in the first cycle after the wake and `stop_active` stays high for `WAKE_CYC` cycles. In the following cycle `stop_active` is low and `wdt_done` is high for exactly one cycle.
- R10: While stopped and not yet woken, `osc_en` is 0. From the first cycle after the wake, `osc_en` returns to the inverse of bit 1.
- R11: A `wake_irq` while running has no effect, and a `stop_req` while stopped or counting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Bus write enable |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_ack | input | 1 | Interrupt acceptance pulse |
| stop_req | input | 1 | Stop request strobe |
| wake_irq | input | 1 | Wake interrupt strobe |
| sysclk_sel | input | 1 | System clock select level |
| wdt_off | input | 1 | Watchdog disable level |
| osc_en | output | 1 | Crystal driver enable |
| xout_high | output | 1 | Hold the clock output pin high |
| stop_active | output | 1 | Stop or stabilisation in progress |
| wdt_start | output | 1 | Start pulse of the stabilisation count |
| wdt_done | output | 1 | One-cycle pulse when the count ends |

## Verification
Two events can coincide in one cycle: the data write that follows the key, and an interrupt acceptance. The bench drives `irq_ack` in the same cycle as an armed data write. It also drives `irq_ack` in an idle cycle between the key write and the data write. In both cases a read-back must show the old bits. A behavioural reference model, updated on each edge, judges every output in every cycle, so the drop must also leave the guard disarmed for the write that follows.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    localparam logic [7:0] UNLOCK_KEY = 8'h55;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAKE = 2'd2
    } stop_state_e;

    // bit 1 : crystal driver off, bit 0 : stop requests blocked
    typedef struct packed {
        logic xtal_off;
        logic stop_block;
    } ctl_bits_t;

    function automatic logic wake_needs_count(ctl_bits_t c, logic sysclk_sel, logic wdt_off);
        return !c.xtal_off || (sysclk_sel && !wdt_off);
    endfunction

    function automatic logic [7:0] ctl_to_byte(ctl_bits_t c);
        return {6'b0, c};
    endfunction

endpackage

// File: rtl/stopclk_keyreg.sv
module stopclk_keyreg
    import stopclk_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              irq_ack,
    output ctl_bits_t         ctl_q,
    output logic              armed
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

    logic hit;
    assign hit = (bus_addr == SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            armed <= 1'b0;
        end else if (irq_ack) begin
            armed <= 1'b0;
        end else if (bus_we) begin
            if (!hit) begin
                armed <= 1'b0;
            end else if (armed) begin
                ctl_q <= ctl_bits_t'(bus_wdata[1:0]);
                armed <= 1'b0;
            end else begin
                armed <= (bus_wdata == UNLOCK_KEY);
            end
        end
    end

endmodule

// File: rtl/stopclk_wakecnt.sv
module stopclk_wakecnt #(
    parameter int unsigned WAKE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expire,
    output logic done
);
    localparam int unsigned CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAKE_CYC - 1);

    logic [CW-1:0] cnt;
    logic          busy;

    assign expire = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= expire;
            if (load) begin
                cnt  <= LOAD_VAL;
                busy <= 1'b1;
            end else if (expire) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/stopclk_seq.sv
module stopclk_seq
    import stopclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stop_req,
    input  logic        wake_irq,
    input  ctl_bits_t   ctl,
    input  logic        sysclk_sel,
    input  logic        wdt_off,
    input  logic        cnt_expire,
    output stop_state_e state,
    output logic        go_count,
    output logic        wdt_start
);
    stop_state_e nxt;
    logic        woke;

    assign woke     = (state == ST_STOP) && wake_irq;
    assign go_count = woke && wake_needs_count(ctl, sysclk_sel, wdt_off);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  if (stop_req && !ctl.stop_block) nxt = ST_STOP;
            ST_STOP: if (woke) nxt = go_count ? ST_WAKE : ST_RUN;
            ST_WAKE: if (cnt_expire) nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            wdt_start <= 1'b0;
        end else begin
            state     <= nxt;
            wdt_start <= go_count;
        end
    end

endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
    import stopclk_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 26,
    parameter int unsigned WAKE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              irq_ack,
    input  logic              stop_req,
    input  logic              wake_irq,
    input  logic              sysclk_sel,
    input  logic              wdt_off,
    output logic              osc_en,
    output logic              xout_high,
    output logic              stop_active,
    output logic              wdt_start,
    output logic              wdt_done
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

    ctl_bits_t   ctl_q;
    logic        armed;
    stop_state_e state;
    logic        go_count;
    logic        cnt_expire;

    stopclk_keyreg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .irq_ack   (irq_ack),
        .ctl_q     (ctl_q),
        .armed     (armed)
    );

    stopclk_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .stop_req   (stop_req),
        .wake_irq   (wake_irq),
        .ctl        (ctl_q),
        .sysclk_sel (sysclk_sel),
        .wdt_off    (wdt_off),
        .cnt_expire (cnt_expire),
        .state      (state),
        .go_count   (go_count),
        .wdt_start  (wdt_start)
    );

    stopclk_wakecnt #(.WAKE_CYC(WAKE_CYC)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (go_count),
        .expire (cnt_expire),
        .done   (wdt_done)
    );

    assign bus_rdata   = (bus_addr == SEL) ? ctl_to_byte(ctl_q) : 8'h00;
    assign xout_high   = ctl_q.xtal_off;
    assign osc_en      = !ctl_q.xtal_off && (state != ST_STOP);
    assign stop_active = (state != ST_RUN);

endmodule

// File: rtl/stopclk_ctrl_chk.sv
module stopclk_ctrl_chk
    import stopclk_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 26
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              irq_ack,
    input logic              stop_req,
    input logic              wake_irq,
    input logic              osc_en,
    input logic              stop_active,
    input logic              wdt_start,
    input logic              wdt_done,
    input ctl_bits_t         ctl_q,
    input logic              armed,
    input stop_state_e       state
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

    logic hit;
    assign hit = (bus_addr == SEL);

    a_r1_key_arms_only: assert property (@(posedge clk) disable iff (rst)
        bus_we && hit && !armed && !irq_ack && bus_wdata == UNLOCK_KEY |=> armed && $stable(ctl_q));

    a_r2_unarmed_keeps: assert property (@(posedge clk) disable iff (rst)
        bus_we && hit && !armed |=> $stable(ctl_q));

    a_r3_irq_drops: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !armed && $stable(ctl_q));

    a_r4_other_disarms: assert property (@(posedge clk) disable iff (rst)
        bus_we && !hit |=> !armed);

    a_r5_blocked_stop: assert property (@(posedge clk) disable iff (rst)
        state == ST_RUN && stop_req && ctl_q.stop_block |=> !stop_active);

    a_r6_xtal_off_osc: assert property (@(posedge clk) disable iff (rst)
        ctl_q.xtal_off |-> !osc_en);

    a_r7_count_forced: assert property (@(posedge clk) disable iff (rst)
        state == ST_STOP && wake_irq && !ctl_q.xtal_off |=> wdt_start && stop_active);

    a_r9_done_after_stop: assert property (@(posedge clk) disable iff (rst)
        wdt_done |-> !stop_active);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        wdt_done |=> !wdt_done);

    a_r10_osc_low_stopped: assert property (@(posedge clk) disable iff (rst)
        state == ST_STOP |-> !osc_en);

    a_r11_wake_in_run: assert property (@(posedge clk) disable iff (rst)
        state == ST_RUN && wake_irq && !stop_req |=> !stop_active);

endmodule

bind stopclk_ctrl stopclk_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .irq_ack     (irq_ack),
    .stop_req    (stop_req),
    .wake_irq    (wake_irq),
    .osc_en      (osc_en),
    .stop_active (stop_active),
    .wdt_start   (wdt_start),
    .wdt_done    (wdt_done),
    .ctl_q       (ctl_q),
    .armed       (armed),
    .state       (state)
);

// File: tb/stopclk_ctrl_test.sv
`timescale 1ns/1ps
module stopclk_ctrl_test;
    localparam int ADDR_W   = 8;
    localparam int REG_ADDR = 26;
    localparam int WAKE_CYC = 16;
    localparam logic [7:0] RA = 8'(REG_ADDR);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0, stop_req = 1'b0, wake_irq = 1'b0;
    logic       sysclk_sel = 1'b0, wdt_off = 1'b0;
    logic       osc_en, xout_high, stop_active, wdt_start, wdt_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    stopclk_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WAKE_CYC(WAKE_CYC)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .stop_req(stop_req), .wake_irq(wake_irq), .sysclk_sel(sysclk_sel),
        .wdt_off(wdt_off), .osc_en(osc_en), .xout_high(xout_high),
        .stop_active(stop_active), .wdt_start(wdt_start), .wdt_done(wdt_done)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 run, 1 stopped, 2 counting
    logic [1:0] m_bits = 2'b00;
    bit m_armed = 0, m_start = 0, m_done = 0;
    int m_st = 0, m_cnt = 0;

    always @(posedge clk) begin
        logic [1:0] nb;
        bit na, ns, nd;
        int nst, nc;
        if (rst) begin
            m_bits = 2'b00; m_armed = 0; m_st = 0; m_cnt = 0; m_start = 0; m_done = 0;
        end else begin
            nb = m_bits; na = m_armed; nst = m_st; nc = m_cnt; ns = 0; nd = 0;
            if (irq_ack) na = 0;
            else if (bus_we) begin
                if (bus_addr != RA) na = 0;
                else if (m_armed) begin nb = bus_wdata[1:0]; na = 0; end
                else na = (bus_wdata == 8'h55);
            end
            if (m_st == 0) begin
                if (stop_req && !m_bits[0]) nst = 1;
            end else if (m_st == 1) begin
                if (wake_irq) begin
                    if (!m_bits[1] || (sysclk_sel && !wdt_off)) begin
                        nst = 2; nc = WAKE_CYC - 1; ns = 1;
                    end else nst = 0;
                end
            end else begin
                if (m_cnt == 0) begin nst = 0; nd = 1; end
                else nc = m_cnt - 1;
            end
            m_bits = nb; m_armed = na; m_st = nst; m_cnt = nc; m_start = ns; m_done = nd;
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            check("R6 xout_high", {7'b0, xout_high}, {7'b0, m_bits[1]});
            check("R10 osc_en", {7'b0, osc_en}, {7'b0, (!m_bits[1] && m_st != 1)});
            check("R5 stop_active", {7'b0, stop_active}, {7'b0, (m_st != 0)});
            check("R9 wdt_start", {7'b0, wdt_start}, {7'b0, m_start});
            check("R9 wdt_done", {7'b0, wdt_done}, {7'b0, m_done});
            check("R2 rdata", bus_rdata, (bus_addr == RA) ? {6'b0, m_bits} : 8'h00);
        end
    end

    task automatic step(logic [7:0] a, logic we, logic [7:0] d, logic ack, logic sr, logic wi);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d; irq_ack = ack; stop_req = sr; wake_irq = wi;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(RA, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic expect_bits(string tag, logic [7:0] exp);
        step(RA, 0, 8'h00, 0, 0, 0);
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    task automatic unlock_write(logic [7:0] d);
        step(RA, 1, 8'h55, 0, 0, 0);
        step(RA, 1, d, 0, 0, 0);
    endtask

    initial begin
        #(4 * 50000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_bits("R2 reset value", 8'h00);
        check("R6 reset osc_en", {7'b0, osc_en}, 8'h01);
        check("R5 reset stop_active", {7'b0, stop_active}, 8'h00);

        step(RA, 1, 8'h03, 0, 0, 0);
        expect_bits("R2 unarmed write ignored", 8'h00);
        step(RA, 1, 8'h55, 0, 0, 0);
        expect_bits("R1 key changes nothing", 8'h00);
        step(RA, 1, 8'h02, 0, 0, 0);
        expect_bits("R2 armed write stores", 8'h02);

        step(RA, 1, 8'h55, 0, 0, 0);
        step(8'h10, 1, 8'h00, 0, 0, 0);
        step(RA, 1, 8'h01, 0, 0, 0);
        expect_bits("R4 other address disarms", 8'h02);

        step(RA, 1, 8'h55, 0, 0, 0);
        step(RA, 1, 8'h55, 0, 0, 0);
        step(RA, 1, 8'h01, 0, 0, 0);
        expect_bits("R4 one write per key", 8'h01);

        step(RA, 1, 8'h55, 0, 0, 0);
        step(RA, 0, 8'h00, 1, 0, 0);
        step(RA, 1, 8'h00, 0, 0, 0);
        expect_bits("R3 irq between key and data", 8'h01);

        step(RA, 1, 8'h55, 0, 0, 0);
        step(RA, 1, 8'h00, 1, 0, 0);
        expect_bits("R3 irq with data write", 8'h01);

        step(RA, 1, 8'h55, 1, 0, 0);
        step(RA, 1, 8'h00, 0, 0, 0);
        expect_bits("R3 irq with key write", 8'h01);

        step(RA, 0, 8'h00, 0, 1, 0);
        idle(2);
        check("R5 stop blocked", {7'b0, stop_active}, 8'h00);

        unlock_write(8'h00);
        expect_bits("R2 cleared", 8'h00);
        step(RA, 0, 8'h00, 0, 0, 1);
        idle(1);
        check("R11 wake in run ignored", {7'b0, stop_active}, 8'h00);

        wdt_off = 1'b1; sysclk_sel = 1'b0;
        step(RA, 0, 8'h00, 0, 1, 0);
        idle(3);
        check("R5 stop entered", {7'b0, stop_active}, 8'h01);
        check("R10 osc off in stop", {7'b0, osc_en}, 8'h00);
        step(RA, 0, 8'h00, 0, 0, 1);
        step(RA, 0, 8'h00, 0, 1, 0);
        idle(3);
        check("R7 counting despite wdt_off", {7'b0, stop_active}, 8'h01);
        check("R10 osc back on wake", {7'b0, osc_en}, 8'h01);
        idle(WAKE_CYC + 3);
        check("R9 back to run", {7'b0, stop_active}, 8'h00);

        unlock_write(8'h02);
        wdt_off = 1'b0; sysclk_sel = 1'b0;
        step(RA, 0, 8'h00, 0, 1, 0);
        idle(2);
        step(RA, 0, 8'h00, 0, 0, 1);
        idle(1);
        check("R8 immediate resume", {7'b0, stop_active}, 8'h00);

        sysclk_sel = 1'b1;
        step(RA, 0, 8'h00, 0, 1, 0);
        idle(2);
        step(RA, 0, 8'h00, 0, 0, 1);
        idle(2);
        check("R8 count with sysclk_sel", {7'b0, stop_active}, 8'h01);
        idle(WAKE_CYC + 2);

        wdt_off = 1'b1;
        step(RA, 0, 8'h00, 0, 1, 0);
        idle(2);
        step(RA, 0, 8'h00, 0, 0, 1);
        idle(1);
        check("R8 wdt_off skips count", {7'b0, stop_active}, 8'h00);
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule